// File: doc/BRIEF.md
# Misaligned Access Exception Detector

This block sits next to a 32-bit processor pipeline and checks two kinds of addresses for alignment. The first is the byte address of each load or store. The second is the destination of each indirect or branch control transfer. When either check fails, the block sends the pipeline a one-cycle exception request. It also records two values for the handler: a cause code, and the address that failed the check. The handler can then act without decoding the faulting instruction.

Data accesses and control-transfer targets go through separate paths and produce separate cause codes. If both kinds of violation occur in the same cycle, the data violation wins. The parameter `CAPTURE_EN` controls whether the cause and address are recorded. When it is 0, the exception request still fires, but both capture outputs stay at zero.

Every output is registered. Inputs sampled at a clock edge show their effect right after that edge. A synchronous active-high reset clears all outputs.

Top module: `misalign_detect`

## Requirements
- R1: A load/store with `memSize` = 2 (word) is misaligned when `memAddr[1:0]` is not 0. The reserved size code 3 is checked the same way as a word.
- R2: A load/store with `memSize` = 1 (half-word) is misaligned when `memAddr[0]` is 1.
- R3: A load/store with `memSize` = 0 (byte) never raises an exception, whatever its address.
- R4: The transfer classes 0 (branch), 1 (register call), 2 (jump), 3 (return), 4 (exception return) and 5 (breakpoint return) are misaligned when `xferTarget[1:0]` is not 0. Classes 6 and 7 are never checked.
- R5: `excPulse` is 1 in the cycle after each input cycle that contains a violation, and 0 after every other input cycle. Two violating cycles in a row therefore give two consecutive high cycles.
- R6: With capture enabled, each violation updates both capture outputs on the same edge that raises `excPulse`. `ctrlReg[6:2]` takes the cause code: 1 for a misaligned data address, 2 for a misaligned destination address, 0 before any exception. `badAddr` takes the address that failed. All other bits of `ctrlReg` read 0.
- R7: When a data violation and a destination violation occur in the same cycle, only the data cause (1) and `memAddr` are captured.
- R8: `ctrlReg` and `badAddr` keep their values until the next violation. A synchronous reset clears `excPulse`, `ctrlReg` and `badAddr` to 0.
- R9: When `memValid` is 0, the memory inputs are ignored. When `xferValid` is 0, the transfer inputs are ignored. An ignored input raises no pulse and changes no capture output.
- R10: With `CAPTURE_EN` = 0, `excPulse` behaves as in R5, and `ctrlReg` and `badAddr` stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| memValid | input | 1 | A load/store address is present this cycle |
| memSize | input | 2 | Access size: 0 byte, 1 half-word, 2 word, 3 reserved (treated as word) |
| memAddr | input | ADDR_W | Load/store byte address |
| xferValid | input | 1 | A control-transfer target is present this cycle |
| xferClass | input | 3 | Transfer kind; 0..5 are checked, 6..7 are not |
| xferTarget | input | ADDR_W | Control-transfer destination byte address |
| excPulse | output | 1 | One-cycle exception request |
| ctrlReg | output | 32 | Exception control word, cause in bits [6:2] |
| badAddr | output | ADDR_W | Address that caused the last captured exception |

## Verification
A wrong alignment decision shows on `excPulse` on the very edge after the faulty input. It appears either as a missing pulse or as a pulse on a legal access. A stuck or mis-steered capture register makes `ctrlReg` or `badAddr` wrong at that same edge, and the error persists until the next violation or reset. The near-exhaustive sweep therefore compares all three outputs after every single input cycle. That sweep covers every size and class against every low address pattern, and includes idle cycles that carry misaligned addresses. A broken priority or hold path then shows within one cycle of the first input pattern that exercises it.

// File: rtl/misalign_pkg.sv
package misalign_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  localparam int CAUSE_W   = 5;
  localparam int CAUSE_LSB = 2;
  localparam int CTRL_W    = 32;
  localparam int CLASS_W   = 3;
  localparam int NUM_CLASS = 1 << CLASS_W;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_DATA = 5'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_DEST = 5'd2;

  // Strobes from control to datapath
  typedef struct packed {
    logic fire;
    logic takeData;
    logic takeDest;
  } excStrobe_t;

endpackage

// File: rtl/misalign_ctrl.sv
module misalign_ctrl
  import misalign_pkg::*;
#(
  parameter logic [NUM_CLASS-1:0] CLASS_MASK = 8'h3F
) (
  input  logic               memValid,
  input  logic [1:0]         memSize,
  input  logic [1:0]         memLow,
  input  logic               xferValid,
  input  logic [CLASS_W-1:0] xferClass,
  input  logic [1:0]         xferLow,
  output excStrobe_t         strobe
);

  logic                 dataMis;
  logic                 destMis;
  logic [NUM_CLASS-1:0] classHit;
  logic                 classChecked;

  // Data alignment by access size
  always_comb begin
    unique case (accSize_e'(memSize))
      SZ_BYTE: dataMis = 1'b0;
      SZ_HALF: dataMis = memLow[0];
      default: dataMis = |memLow;
    endcase
  end

  // Per-class enable built from the mask
  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    assign classHit[c] = CLASS_MASK[c] && (xferClass == CLASS_W'(c));
  end
  assign classChecked = |classHit;

  assign destMis = classChecked && (|xferLow);

  // Data path has priority
  always_comb begin
    strobe          = '0;
    strobe.takeData = memValid && dataMis;
    strobe.takeDest = xferValid && destMis && !strobe.takeData;
    strobe.fire     = strobe.takeData || strobe.takeDest;
  end

endmodule

// File: rtl/misalign_dp.sv
module misalign_dp
  import misalign_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter bit CAPTURE_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  excStrobe_t         strobe,
  input  logic [ADDR_W-1:0]  memAddr,
  input  logic [ADDR_W-1:0]  xferTarget,
  output logic               excPulse,
  output logic [CAUSE_W-1:0] cause,
  output logic [ADDR_W-1:0]  badAddr
);

  always_ff @(posedge clk) begin
    if (rst) excPulse <= 1'b0;
    else     excPulse <= strobe.fire;
  end

  if (CAPTURE_EN) begin : g_cap
    logic [ADDR_W-1:0]  nextAddr;
    logic [CAUSE_W-1:0] nextCause;

    always_comb begin
      nextAddr  = strobe.takeData ? memAddr : xferTarget;
      nextCause = strobe.takeData ? CAUSE_DATA : CAUSE_DEST;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cause   <= CAUSE_NONE;
        badAddr <= '0;
      end else if (strobe.fire) begin
        cause   <= nextCause;
        badAddr <= nextAddr;
      end
    end
  end else begin : g_nocap
    assign cause   = CAUSE_NONE;
    assign badAddr = '0;
  end

endmodule

// File: rtl/misalign_detect.sv
module misalign_detect
  import misalign_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter bit CAPTURE_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               memValid,
  input  logic [1:0]         memSize,
  input  logic [ADDR_W-1:0]  memAddr,
  input  logic               xferValid,
  input  logic [CLASS_W-1:0] xferClass,
  input  logic [ADDR_W-1:0]  xferTarget,
  output logic               excPulse,
  output logic [CTRL_W-1:0]  ctrlReg,
  output logic [ADDR_W-1:0]  badAddr
);

  localparam int CAUSE_MSB = CAUSE_LSB + CAUSE_W - 1;

  excStrobe_t         strobe;
  logic [CAUSE_W-1:0] causeQ;

  misalign_ctrl #(
    .CLASS_MASK(8'h3F)
  ) u_ctrl (
    .memValid (memValid),
    .memSize  (memSize),
    .memLow   (memAddr[1:0]),
    .xferValid(xferValid),
    .xferClass(xferClass),
    .xferLow  (xferTarget[1:0]),
    .strobe   (strobe)
  );

  misalign_dp #(
    .ADDR_W    (ADDR_W),
    .CAPTURE_EN(CAPTURE_EN)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .memAddr   (memAddr),
    .xferTarget(xferTarget),
    .excPulse  (excPulse),
    .cause     (causeQ),
    .badAddr   (badAddr)
  );

  always_comb begin
    ctrlReg                      = '0;
    ctrlReg[CAUSE_MSB:CAUSE_LSB] = causeQ;
  end

endmodule

// File: rtl/misalign_chk.sv
module misalign_chk #(
  parameter int ADDR_W     = 32,
  parameter bit CAPTURE_EN = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              memValid,
  input logic [1:0]        memSize,
  input logic [ADDR_W-1:0] memAddr,
  input logic              xferValid,
  input logic [2:0]        xferClass,
  input logic [ADDR_W-1:0] xferTarget,
  input logic              excPulse,
  input logic [31:0]       ctrlReg,
  input logic [ADDR_W-1:0] badAddr
);

  logic dataBadNow;
  logic destBadNow;
  logic anyBad;

  always_comb begin
    dataBadNow = memValid &&
                 ((memSize == 2'd1) ? memAddr[0] :
                  (memSize == 2'd0) ? 1'b0 : (memAddr[1:0] != 2'b00));
    destBadNow = xferValid && (xferClass < 3'd6) && (xferTarget[1:0] != 2'b00);
    anyBad     = dataBadNow || destBadNow;
  end

  assert_byte_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (memValid && memSize == 2'd0 && !xferValid) |=> !excPulse);

  assert_pulse_after_R5: assert property (@(posedge clk) disable iff (rst)
    anyBad |=> excPulse);

  assert_pulse_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !anyBad |=> !excPulse);

  if (CAPTURE_EN) begin : g_capchk
    assert_data_capture_R6: assert property (@(posedge clk) disable iff (rst)
      dataBadNow |=> (ctrlReg[6:2] == 5'd1 && badAddr == $past(memAddr)));

    assert_dest_capture_R6: assert property (@(posedge clk) disable iff (rst)
      (destBadNow && !dataBadNow) |=> (ctrlReg[6:2] == 5'd2 && badAddr == $past(xferTarget)));

    assert_data_wins_R7: assert property (@(posedge clk) disable iff (rst)
      (dataBadNow && destBadNow) |=> (ctrlReg[6:2] == 5'd1));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !anyBad |=> ($stable(ctrlReg) && $stable(badAddr)));
  end else begin : g_nocapchk
    assert_zero_regs_R10: assert property (@(posedge clk) disable iff (rst)
      anyBad |=> (ctrlReg == 32'd0 && badAddr == '0));
  end

endmodule

bind misalign_detect misalign_chk #(
  .ADDR_W    (ADDR_W),
  .CAPTURE_EN(CAPTURE_EN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .memValid  (memValid),
  .memSize   (memSize),
  .memAddr   (memAddr),
  .xferValid (xferValid),
  .xferClass (xferClass),
  .xferTarget(xferTarget),
  .excPulse  (excPulse),
  .ctrlReg   (ctrlReg),
  .badAddr   (badAddr)
);

// File: tb/test_misalign_detect.sv
module test_misalign_detect;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        memValid = 1'b0;
  logic [1:0]  memSize = 2'd0;
  logic [31:0] memAddr = 32'd0;
  logic        xferValid = 1'b0;
  logic [2:0]  xferClass = 3'd0;
  logic [31:0] xferTarget = 32'd0;

  logic        excPulse, excPulseN;
  logic [31:0] ctrlReg, ctrlRegN, badAddr, badAddrN;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic        expPulse = 1'b0;
  logic [31:0] expCtrl = 32'd0;
  logic [31:0] expAddr = 32'd0;

  always #4 clk = ~clk;

  misalign_detect #(.ADDR_W(32), .CAPTURE_EN(1'b1)) i_misalign_detect (
    .clk(clk), .rst(rst), .memValid(memValid), .memSize(memSize), .memAddr(memAddr),
    .xferValid(xferValid), .xferClass(xferClass), .xferTarget(xferTarget),
    .excPulse(excPulse), .ctrlReg(ctrlReg), .badAddr(badAddr));

  misalign_detect #(.ADDR_W(32), .CAPTURE_EN(1'b0)) i_misalign_detect_nocap (
    .clk(clk), .rst(rst), .memValid(memValid), .memSize(memSize), .memAddr(memAddr),
    .xferValid(xferValid), .xferClass(xferClass), .xferTarget(xferTarget),
    .excPulse(excPulseN), .ctrlReg(ctrlRegN), .badAddr(badAddrN));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit dataBad(input logic [1:0] sz, input logic [31:0] a);
    if (sz == 2'd0) return 1'b0;
    if (sz == 2'd1) return a[0];
    return a[1:0] != 2'b00;
  endfunction

  function automatic bit destBad(input logic [2:0] cls, input logic [31:0] t);
    return (cls <= 3'd5) && (t[1:0] != 2'b00);
  endfunction

  task automatic checkAll(input string req);
    check({req, " R5"}, "excPulse", {31'd0, excPulse}, {31'd0, expPulse});
    check({req, " R6"}, "ctrlReg", ctrlReg, expCtrl);
    check({req, " R8"}, "badAddr", badAddr, expAddr);
    check("R10", "nocap excPulse", {31'd0, excPulseN}, {31'd0, expPulse});
    check("R10", "nocap ctrlReg", ctrlRegN, 32'd0);
    check("R10", "nocap badAddr", badAddrN, 32'd0);
  endtask

  task automatic step(input logic mv, input logic [1:0] ms, input logic [31:0] ma,
                      input logic xv, input logic [2:0] xc, input logic [31:0] xt,
                      input string req);
    bit db, xb;
    @(negedge clk);
    memValid = mv; memSize = ms; memAddr = ma;
    xferValid = xv; xferClass = xc; xferTarget = xt;
    db = mv && dataBad(ms, ma);
    xb = xv && destBad(xc, xt);
    expPulse = db || xb;
    if (db) begin
      expCtrl = 32'd1 << 2; expAddr = ma;
    end else if (xb) begin
      expCtrl = 32'd2 << 2; expAddr = xt;
    end
    @(posedge clk);
    #1;
    checkAll(req);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; memValid = 1'b0; xferValid = 1'b0;
    @(posedge clk);
    #1;
    expPulse = 1'b0; expCtrl = 32'd0; expAddr = 32'd0;
    checkAll("R8 reset");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] uppers [3];
    uppers[0] = 32'h0000_0000;
    uppers[1] = 32'h1234_5670;
    uppers[2] = 32'hFFFF_FFF0;

    repeat (2) @(posedge clk);
    doReset();

    // Load/store sweep: size x low bits x upper pattern (R1, R2, R3)
    for (int sz = 0; sz < 4; sz++)
      for (int lo = 0; lo < 4; lo++)
        for (int u = 0; u < 3; u++)
          step(1'b1, 2'(sz), uppers[u] | 32'(lo), 1'b0, 3'd0, 32'd0,
               (sz == 0) ? "R3" : (sz == 1) ? "R2" : "R1");

    // Transfer sweep: class x low bits (R4)
    for (int c = 0; c < 8; c++)
      for (int lo = 0; lo < 4; lo++)
        for (int u = 1; u < 3; u++)
          step(1'b0, 2'd0, 32'd0, 1'b1, 3'(c), uppers[u] | 32'(lo), "R4");

    // Same-cycle combinations (R7)
    for (int ml = 0; ml < 4; ml++)
      for (int tl = 0; tl < 4; tl++)
        step(1'b1, 2'd2, 32'hA000_0000 | 32'(ml), 1'b1, 3'd3, 32'hB000_0000 | 32'(tl), "R7");

    // Back-to-back violations then idle cycles with bad addresses (R5, R9, R8)
    step(1'b1, 2'd1, 32'h0000_1001, 1'b0, 3'd0, 32'd0, "R5 first");
    step(1'b0, 2'd0, 32'd0, 1'b1, 3'd4, 32'h0000_2002, "R5 second");
    for (int k = 0; k < 4; k++)
      step(1'b0, 2'd2, 32'h0000_3003, 1'b0, 3'd1, 32'h0000_4001, "R9");
    for (int k = 0; k < 3; k++)
      step(1'b1, 2'd0, 32'h0000_5003, 1'b1, 3'd7, 32'h0000_6003, "R8 hold");

    // Reset mid-run clears captured state (R8)
    step(1'b1, 2'd2, 32'h7777_7772, 1'b0, 3'd0, 32'd0, "R1");
    doReset();
    step(1'b0, 2'd0, 32'd0, 1'b0, 3'd0, 32'd0, "R8 after reset");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule